// File: doc/BRIEF.md
# Monitored Glitch-Free Clock Selector

This block picks the system clock from one of two free-running oscillators, an internal one and an external one. The two oscillators are asynchronous to each other. Software changes the source by writing a select bit. The write takes effect only if the target oscillator is reported both enabled and stable. The changeover uses a pair of synchronizer chains, one in each clock domain. The old source's gate closes on its own falling edge. The new source's gate opens on its falling edge only after the old gate is seen closed. As a result, the output never shows a shortened high or low phase.

A clock monitor outside the block supplies one "inactive" flag per oscillator, and a monitor-enable input arms the failover. If the monitor is armed and exactly one oscillator is flagged inactive, the block clears that oscillator's gate chain asynchronously, because a stopped clock cannot step its own flops. The surviving side then opens its gate through a shortened one-flop path. The select register also moves to the survivor, so the selection stays there after the flag clears. A status bit reports which oscillator actually drives the output. It changes only after the new gate has opened.

The recommended software order is: enable the new oscillator, wait for it to report stable, write the select bit, then disable the old oscillator.

Top module: `gf_clk_switch`

## Requirements
- R1: While reset is asserted and right after it is released, `clk_out` follows `clk_int` and `sel_status` is 0. Encoding: 0 means internal, 1 means external.
- R2: A select write of value 1 while `ext_on` and `ext_stable` are both high makes `clk_out` follow `clk_ext` and sets `sel_status` to 1. A write of 0 under the matching internal conditions returns to `clk_int`. Lowering the old source's on/stable inputs after the switch has no effect on the output.
- R3: A select write is ignored when the requested source's on input or its stable input is low. Both the output clock and `sel_status` keep their previous values.
- R4: Every high and low phase of `clk_out` is at least as long as the shorter half-period of the two input clocks, including across switches and failovers.
- R5: `sel_status` does not change until the newly chosen source is gating the output. Immediately after an accepted write it still shows the old source.
- R6: With `mon_en` high, raising `ext_off` while `int_off` is low forces the internal source. `clk_out` produces its next rising edge within two `clk_int` periods of the flag rising, and `sel_status` becomes 0.
- R7: With `mon_en` high, raising `int_off` while `ext_off` is low forces the external source, and `sel_status` becomes 1.
- R8: With `mon_en` low, the inactive flags have no effect on the output clock or on `sel_status`.
- R9: If both inactive flags are high at once, the present selection is kept unchanged.
- R10: After a forced failover, clearing the inactive flag leaves the survivor selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Clock of the select register and status logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_int | input | 1 | Internal oscillator clock |
| clk_ext | input | 1 | External oscillator clock |
| int_on | input | 1 | Internal oscillator enabled |
| int_stable | input | 1 | Internal oscillator reported stable |
| ext_on | input | 1 | External oscillator enabled |
| ext_stable | input | 1 | External oscillator reported stable |
| mon_en | input | 1 | Arms monitor-driven failover |
| int_off | input | 1 | Monitor flag: internal clock inactive |
| ext_off | input | 1 | Monitor flag: external clock inactive |
| sel_wr | input | 1 | Select-register write strobe (bus_clk domain) |
| sel_wr_val | input | 1 | Requested source: 0 internal, 1 external |
| clk_out | output | 1 | Selected, glitch-free clock |
| sel_status | output | 1 | Source currently driving clk_out (0 internal, 1 external) |

## Verification
The bench timestamps every edge of `clk_out` and flags any phase shorter than 7 ns, the internal half-period. A selector that gated on rising edges, or opened the new gate before the old one closed, would produce runt pulses there. Failover is tested by stopping each oscillator in turn before raising its flag. A design that waited for the dead clock to clear its own chain would never switch, and the output would stay silent. A design without the shortened path would miss the two-period limit. Rejected writes, a disarmed monitor and both flags raised together are each followed by a period and status measurement. A design that let any of them move the selection would show the wrong period.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;
   localparam int NUM_SRC = 2;
   localparam int SRC_INT = 0;
   localparam int SRC_EXT = 1;
   typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/1ps
module clksw_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("clksw_sync needs at least two stages");
   end
   if (W < 1) begin : g_bad_width
      $error("clksw_sync needs a positive width");
   end

   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      end else begin
         pipe[0] <= d;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/clksw_side.sv
`timescale 1ns/1ps
module clksw_side #(
   parameter int STAGES   = 2,
   parameter bit START_ON = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,    // asynchronous: this side wanted and other gate closed
   input  logic kill,   // asynchronous clear, other side forced
   input  logic fast,   // this side forced: open after one flop
   output logic en
);
   if (STAGES < 2) begin : g_bad_depth
      $error("clksw_side needs at least two stages");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n or posedge kill) begin
      if (!rst_n)    chain <= {STAGES{START_ON}};
      else if (kill) chain <= '0;
      else           chain <= {chain[STAGES-2:0], req};
   end

   // gate changes only while this clock is low
   always_ff @(negedge clk or negedge rst_n or posedge kill) begin
      if (!rst_n)    en <= START_ON;
      else if (kill) en <= 1'b0;
      else           en <= fast ? chain[0] : chain[STAGES-1];
   end
endmodule

// File: rtl/clksw_ctrl.sv
`timescale 1ns/1ps
module clksw_ctrl
   import clksw_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic     bus_clk,
   input  logic     rst_n,
   input  logic     wr,
   input  logic     wr_val,
   input  src_vec_t src_on,
   input  src_vec_t src_stable,
   input  src_vec_t forced,     // forced[i]: side i must take over
   input  src_vec_t gate_en,    // raw gate enables from both domains
   output logic     sel_q,
   output logic     status
);
   src_vec_t forced_s, gate_s;
   logic     target_ok;

   clksw_sync #(.STAGES(STAGES), .W(NUM_SRC)) u_force_sync (
      .clk(bus_clk), .rst_n(rst_n), .d(forced), .q(forced_s));
   clksw_sync #(.STAGES(STAGES), .W(NUM_SRC)) u_gate_sync (
      .clk(bus_clk), .rst_n(rst_n), .d(gate_en), .q(gate_s));

   assign target_ok = src_on[wr_val] & src_stable[wr_val];

   always_ff @(posedge bus_clk or negedge rst_n) begin
      if (!rst_n)                  sel_q <= 1'b0;
      else if (forced_s[SRC_INT])  sel_q <= 1'b0;
      else if (forced_s[SRC_EXT])  sel_q <= 1'b1;
      else if (wr && target_ok)    sel_q <= wr_val;
   end

   always_ff @(posedge bus_clk or negedge rst_n) begin
      if (!rst_n)                  status <= 1'b0;
      else if (gate_s == 2'b10)    status <= 1'b1;
      else if (gate_s == 2'b01)    status <= 1'b0;
   end

   a_r3_write_gate: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (wr && !target_ok && forced_s == '0) |=> (sel_q == $past(sel_q)));

   a_r5_status_after_gate: assert property (@(posedge bus_clk) disable iff (!rst_n)
      $rose(status) |-> $past(gate_s) == 2'b10);
endmodule

// File: rtl/gf_clk_switch.sv
`timescale 1ns/1ps
module gf_clk_switch
   import clksw_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic bus_clk,
   input  logic rst_n,
   input  logic clk_int,
   input  logic clk_ext,
   input  logic int_on,
   input  logic int_stable,
   input  logic ext_on,
   input  logic ext_stable,
   input  logic mon_en,
   input  logic int_off,
   input  logic ext_off,
   input  logic sel_wr,
   input  logic sel_wr_val,
   output logic clk_out,
   output logic sel_status
);
   if (SYNC_STAGES < 2) begin : g_bad_depth
      $error("gf_clk_switch needs SYNC_STAGES >= 2");
   end

   src_vec_t clks, forced, want, gate_en, src_on, src_stable;
   logic     sel_q;

   assign clks       = {clk_ext, clk_int};
   assign src_on     = {ext_on, int_on};
   assign src_stable = {ext_stable, int_stable};

   // failover only when exactly one side is flagged
   assign forced[SRC_INT] = mon_en & ext_off & ~int_off;
   assign forced[SRC_EXT] = mon_en & int_off & ~ext_off;

   assign want[SRC_EXT] = forced[SRC_EXT] | (~forced[SRC_INT] & sel_q);
   assign want[SRC_INT] = ~want[SRC_EXT];

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_side
      clksw_side #(.STAGES(SYNC_STAGES), .START_ON(g == SRC_INT)) u_side (
         .clk  (clks[g]),
         .rst_n(rst_n),
         .req  (want[g] & ~gate_en[NUM_SRC-1-g]),
         .kill (forced[NUM_SRC-1-g]),
         .fast (forced[g]),
         .en   (gate_en[g]));
   end

   clksw_ctrl #(.STAGES(SYNC_STAGES)) u_ctrl (
      .bus_clk   (bus_clk),
      .rst_n     (rst_n),
      .wr        (sel_wr),
      .wr_val    (sel_wr_val),
      .src_on    (src_on),
      .src_stable(src_stable),
      .forced    (forced),
      .gate_en   (gate_en),
      .sel_q     (sel_q),
      .status    (sel_status));

   assign clk_out = (clk_int & gate_en[SRC_INT]) | (clk_ext & gate_en[SRC_EXT]);

   a_r4_one_gate: assert property (@(posedge bus_clk) disable iff (!rst_n)
      $onehot0(gate_en));

   a_r6_dead_ext_closed: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (mon_en && ext_off && !int_off) |-> !gate_en[SRC_EXT]);

   a_r7_dead_int_closed: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (mon_en && int_off && !ext_off) |-> !gate_en[SRC_INT]);

   always_ff @(posedge bus_clk) begin
      if (!rst_n) begin
         a_r1_reset_internal: assert (gate_en == 2'b01 && !sel_status);
      end
   end
endmodule

// File: tb/gf_clk_switch_test.sv
`timescale 1ns/1ps
module gf_clk_switch_test;
   localparam real BUS_HALF = 2.5;   // 200 MHz
   localparam real INT_HALF = 7.0;
   localparam real EXT_HALF = 11.0;
   localparam real MIN_PHASE = 7.0;

   logic bus_clk = 0, rst_n = 1, clk_int = 0, clk_ext = 0;
   logic int_on = 1, int_stable = 1, ext_on = 0, ext_stable = 0;
   logic mon_en = 0, int_off = 0, ext_off = 0, sel_wr = 0, sel_wr_val = 0;
   logic clk_out, sel_status;
   bit   int_run = 1, ext_run = 1, phase_mon = 0;
   int   checks = 0, failures = 0, runts = 0;
   realtime last_edge = 0;

   gf_clk_switch uut (.*);

   always #(BUS_HALF) bus_clk = ~bus_clk;
   always begin #(INT_HALF); clk_int = int_run ? ~clk_int : 1'b0; end
   always begin #(EXT_HALF); clk_ext = ext_run ? ~clk_ext : 1'b0; end

   // R4: runt detector on every output edge
   always @(clk_out) begin
      if (phase_mon && ($realtime - last_edge) < MIN_PHASE - 0.01) begin
         runts++;
         $display("FAIL R4 phase %f ns, expected >= %f ns at %t",
                  $realtime - last_edge, MIN_PHASE, $realtime);
      end
      last_edge = $realtime;
   end

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   task automatic check(input bit ok, input string req, input real act, input real exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%f expected=%f", req, act, exp);
      end
   endtask

   task automatic expect_period(input real want, input string req);
      realtime t0, p;
      @(posedge clk_out); t0 = $realtime;
      @(posedge clk_out); p = $realtime - t0;
      check(p > want - 0.1 && p < want + 0.1, req, p, want);
   endtask

   task automatic expect_status(input logic want, input string req);
      @(negedge bus_clk);
      check(sel_status === want, req, real'(sel_status), real'(want));
   endtask

   task automatic write_sel(input logic v);
      @(negedge bus_clk); sel_wr = 1; sel_wr_val = v;
      @(negedge bus_clk); sel_wr = 0;
   endtask

   task automatic t_reset();
      rst_n = 0;
      #50;
      expect_period(2*INT_HALF, "R1 period in reset");
      expect_status(1'b0, "R1 status in reset");
      @(negedge bus_clk); rst_n = 1;
      #40;
      expect_period(2*INT_HALF, "R1 period after reset");
      expect_status(1'b0, "R1 status after reset");
      phase_mon = 1;
   endtask

   task automatic t_to_ext();
      ext_on = 1; #30; ext_stable = 1;
      write_sel(1'b1);
      #10;
      expect_status(1'b0, "R5 status before new gate opens");
      #300;
      expect_period(2*EXT_HALF, "R2 external period");
      expect_status(1'b1, "R2 status external");
      int_on = 0; int_stable = 0;     // old source switched off
      #100;
      expect_period(2*EXT_HALF, "R2 old source off no effect");
   endtask

   task automatic t_reject();
      write_sel(1'b0);                // internal not on
      #300;
      expect_period(2*EXT_HALF, "R3 reject not-on period");
      expect_status(1'b1, "R3 reject not-on status");
      int_on = 1;                     // on but not stable
      write_sel(1'b0);
      #300;
      expect_period(2*EXT_HALF, "R3 reject unstable period");
      expect_status(1'b1, "R3 reject unstable status");
      int_stable = 1;
   endtask

   task automatic t_to_int();
      write_sel(1'b0);
      #300;
      expect_period(2*INT_HALF, "R2 back to internal period");
      expect_status(1'b0, "R2 back to internal status");
   endtask

   task automatic t_fail_ext();
      realtime t0, dt;
      write_sel(1'b1);
      #300;
      mon_en = 1;
      ext_run = 0; #40;
      t0 = $realtime; ext_off = 1;
      @(posedge clk_out); dt = $realtime - t0;
      check(dt <= 4*INT_HALF + 0.5, "R6 failover latency", dt, 4*INT_HALF);
      #200;
      expect_period(2*INT_HALF, "R6 forced internal period");
      expect_status(1'b0, "R6 forced internal status");
      ext_run = 1; #60; ext_off = 0;
      #300;
      expect_period(2*INT_HALF, "R10 internal kept after flag clears");
      expect_status(1'b0, "R10 status kept internal");
   endtask

   task automatic t_fail_int();
      int_run = 0; #40;
      int_off = 1;
      #300;
      expect_period(2*EXT_HALF, "R7 forced external period");
      expect_status(1'b1, "R7 forced external status");
      int_run = 1; #60; int_off = 0;
      #300;
      expect_period(2*EXT_HALF, "R10 external kept after flag clears");
   endtask

   task automatic t_mon_off();
      mon_en = 0; ext_off = 1;
      #300;
      expect_period(2*EXT_HALF, "R8 disarmed monitor period");
      expect_status(1'b1, "R8 disarmed monitor status");
      ext_off = 0;
   endtask

   task automatic t_both_off();
      mon_en = 1; int_off = 1; ext_off = 1;
      #300;
      expect_period(2*EXT_HALF, "R9 both flagged period");
      expect_status(1'b1, "R9 both flagged status");
      int_off = 0; ext_off = 0; mon_en = 0;
   endtask

   initial begin
      #3;
      t_reset();
      t_to_ext();
      t_reject();
      t_to_int();
      t_fail_ext();
      t_fail_int();
      t_mon_off();
      t_both_off();
      t_to_int();
      checks++;
      if (runts != 0) failures++;      // R4 summary check, lines printed above
      report();
      $finish;
   end

   initial begin
      #200000;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
      $finish;
   end
endmodule